// File: doc/BRIEF.md
# Serial Receive Interrupt Source Selector

This block drives the single interrupt request of a synchronous serial receiver. A two-bit mode field, held in a 16-bit control word, picks which receiver event raises the request. The four candidates are a new received word (the ready flag going high), a crossing of a 16-slot channel block or the end of a frame during multichannel reception, an incoming frame-sync pulse, and a frame-sync error. The request is a one-cycle pulse in the internal clock domain.

The external frame-sync is asynchronous. A two-flop synchronizer and a rising-edge detector bring it into the internal clock domain, and that path keeps running while the receiver is held in reset. A slot tracker counts channel strobes modulo 16 inside each frame and starts over at every frame start. Only the selected source reaches the output. Events from the other sources are dropped, not stored. The ready and sync-error flags are always passed to status outputs, whatever the mode.

Top module: `rx_irq_mux`

## Requirements
- R1: The mode field is bits 5:4 of the 16-bit control word, written when `cfg_wr` is high. `cfg_rdata` returns the field at bits 5:4 and zero in every other bit. The field resets to 00.
- R2: In mode 00, `irq` goes high for one cycle, on the clock edge at which `rdy_flag` is first sampled high after being sampled low.
- R3: In mode 01 with `mc_en` high, `irq` goes high on the edge that samples the strobe completing the 16th slot of a block (slots 16, 32, ... counted from frame start).
- R4: In mode 01 with `mc_en` high, a strobe with `chan_last` high raises `irq` on the same edge. The slot count restarts after that strobe and at every synchronized frame-sync rising edge.
- R5: In mode 01 with `mc_en` low, `irq` never goes high.
- R6: In mode 10, a rising edge of `fsync_raw` raises `irq` for exactly one cycle, on the third clock edge that samples it high. A frame-sync held high gives only one pulse.
- R7: In mode 10, R6 still holds while `rcv_reset` is high.
- R8: In mode 11, `irq` goes high for one cycle on the edge at which `serr_flag` is first sampled high after being sampled low.
- R9: `stat_ready` follows `rdy_flag` and `stat_syncerr` follows `serr_flag` in every mode.
- R10: An event from a source other than the selected one does not raise `irq`, and it does not raise `irq` later when the mode is switched to its source.
- R11: Outside mode 10, `rcv_reset` high holds `irq` low and clears the edge history of the flags. A flag still high when `rcv_reset` falls raises `irq` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rcv_reset | input | 1 | Receiver held in reset (active high) |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word read data |
| rdy_flag | input | 1 | Receive-ready flag |
| serr_flag | input | 1 | Frame-sync error flag |
| fsync_raw | input | 1 | Asynchronous receive frame-sync |
| chan_strobe | input | 1 | One-cycle strobe per completed channel slot |
| chan_last | input | 1 | Marks the strobe of the last slot in a frame |
| mc_en | input | 1 | Multichannel selection enabled |
| stat_ready | output | 1 | Ready flag status |
| stat_syncerr | output | 1 | Sync-error flag status |
| irq | output | 1 | Receive interrupt pulse |

## Verification
Flag edges and channel strobes produce their interrupt on the first clock edge that samples them. The frame-sync takes three edges because of the two synchronizer stages. A mode write takes effect on the edge after the write. The bench drives every input on the falling clock edge and samples `irq` on the following falling edge, or three edges later for frame-sync stimulus. A behavioural reference model, updated on each rising edge from the same sampled inputs, predicts `irq` for every cycle and is compared on every falling edge.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;
    typedef enum logic [1:0] {
        IM_READY = 2'b00,
        IM_MCBLK = 2'b01,
        IM_FSYNC = 2'b10,
        IM_SERR  = 2'b11
    } irq_mode_e;

    typedef struct packed {
        irq_mode_e mode;
        logic      irq;
    } sel_state_t;
endpackage

// File: rtl/rxirq_rise.sv
// Rising-edge detector with a synchronous clear of its history
module rxirq_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic din,
    output logic rise
);
    logic hist_d, hist_q;

    always_comb begin
        hist_d = clr ? 1'b0 : din;
        rise   = din & ~hist_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= hist_d;
    end
endmodule

// File: rtl/rxirq_fsync.sv
// Multi-stage synchronizer for the asynchronous frame-sync plus edge detect
module rxirq_fsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fs_async,
    output logic fs_rise
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d    = {sh_q[DEPTH-2:0], fs_async};
        fs_rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/rxirq_blk.sv
// Channel slot tracker: flags block boundaries and frame end
module rxirq_blk #(
    parameter int BLK_CH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic strobe,
    input  logic last,
    output logic boundary
);
    localparam int CW = (BLK_CH > 1) ? $clog2(BLK_CH) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(BLK_CH - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          wrap;

    always_comb begin
        wrap     = (cnt_q == CNT_TOP);
        boundary = strobe & (last | wrap);
        cnt_d    = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (strobe)
            cnt_d = (last | wrap) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rx_irq_mux.sv
module rx_irq_mux
    import rxirq_pkg::*;
#(
    parameter int CFG_W       = 16,
    parameter int MODE_LSB    = 4,
    parameter int BLK_CH      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rcv_reset,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             rdy_flag,
    input  logic             serr_flag,
    input  logic             fsync_raw,
    input  logic             chan_strobe,
    input  logic             chan_last,
    input  logic             mc_en,
    output logic             stat_ready,
    output logic             stat_syncerr,
    output logic             irq
);
    localparam int MODE_MSB = MODE_LSB + 1;
    localparam int NFLAG    = 2;

    sel_state_t       st_d, st_q;
    logic [NFLAG-1:0] flag_in, flag_rise;
    logic             fs_rise, blk_evt, blk_clr, evt;

    assign flag_in = {serr_flag, rdy_flag};

    genvar gi;
    generate
        for (gi = 0; gi < NFLAG; gi++) begin : g_flag
            rxirq_rise u_rise (
                .clk  (clk),
                .rst_n(rst_n),
                .clr  (rcv_reset),
                .din  (flag_in[gi]),
                .rise (flag_rise[gi])
            );
        end
    endgenerate

    rxirq_fsync #(.STAGES(SYNC_STAGES)) u_fs (
        .clk     (clk),
        .rst_n   (rst_n),
        .fs_async(fsync_raw),
        .fs_rise (fs_rise)
    );

    assign blk_clr = rcv_reset | fs_rise;

    rxirq_blk #(.BLK_CH(BLK_CH)) u_blk (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (blk_clr),
        .strobe  (chan_strobe),
        .last    (chan_last),
        .boundary(blk_evt)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_wr)
            st_d.mode = irq_mode_e'(cfg_wdata[MODE_MSB:MODE_LSB]);
        unique case (st_q.mode)
            IM_READY: evt = flag_rise[0] & ~rcv_reset;
            IM_MCBLK: evt = blk_evt & mc_en & ~rcv_reset;
            IM_FSYNC: evt = fs_rise;
            IM_SERR:  evt = flag_rise[1] & ~rcv_reset;
            default:  evt = 1'b0;
        endcase
        st_d.irq = evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: IM_READY, irq: 1'b0};
        else        st_q <= st_d;
    end

    always_comb begin
        cfg_rdata                    = '0;
        cfg_rdata[MODE_MSB:MODE_LSB] = st_q.mode;
    end

    assign stat_ready   = rdy_flag;
    assign stat_syncerr = serr_flag;
    assign irq          = st_q.irq;
endmodule

// File: rtl/rx_irq_mux_chk.sv
module rx_irq_mux_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rcv_reset,
    input logic        rdy_flag,
    input logic        serr_flag,
    input logic        chan_strobe,
    input logic        mc_en,
    input logic [15:0] cfg_rdata,
    input logic        irq
);
    logic [1:0] mode;
    assign mode = cfg_rdata[5:4];

    AST_CFG_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[15:6] == '0) && (cfg_rdata[3:0] == '0)); // R1

    AST_READY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(mode) == 2'b00) |-> $past(rdy_flag)); // R2

    AST_BLOCK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(mode) == 2'b01) |-> $past(chan_strobe && mc_en)); // R3

    AST_MC_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!mc_en && mode == 2'b01) |=> !irq); // R5

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && mode != 2'b01 && $stable(mode)) |=> !irq); // R6

    AST_SERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(mode) == 2'b11) |-> $past(serr_flag)); // R8

    AST_RCV_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_reset && mode != 2'b10) |=> !irq); // R11
endmodule

bind rx_irq_mux rx_irq_mux_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rcv_reset  (rcv_reset),
    .rdy_flag   (rdy_flag),
    .serr_flag  (serr_flag),
    .chan_strobe(chan_strobe),
    .mc_en      (mc_en),
    .cfg_rdata  (cfg_rdata),
    .irq        (irq)
);

// File: tb/sim_rx_irq_mux.sv
`timescale 1ns/1ps
module sim_rx_irq_mux;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rcv_reset = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        rdy_flag = 1'b0;
    logic        serr_flag = 1'b0;
    logic        fsync_raw = 1'b0;
    logic        chan_strobe = 1'b0;
    logic        chan_last = 1'b0;
    logic        mc_en = 1'b0;
    logic        stat_ready, stat_syncerr, irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    rx_irq_mux u0 (
        .clk(clk), .rst_n(rst_n), .rcv_reset(rcv_reset),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .rdy_flag(rdy_flag), .serr_flag(serr_flag), .fsync_raw(fsync_raw),
        .chan_strobe(chan_strobe), .chan_last(chan_last), .mc_en(mc_en),
        .stat_ready(stat_ready), .stat_syncerr(stat_syncerr), .irq(irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference: integers and a queue for the frame-sync delay
    int   m_mode = 0, m_cnt = 0;
    bit   m_rdy_prev = 0, m_serr_prev = 0, m_fs_prev = 0;
    bit   m_fs_q[$] = '{0, 0};
    bit   exp_irq = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_rdy_prev = 0; m_serr_prev = 0;
            m_fs_prev = 0; m_fs_q = '{0, 0}; exp_irq = 0;
        end else begin
            bit fs_now, fs_edge, rdy_edge, serr_edge, slot_evt;
            fs_now    = m_fs_q[1];
            fs_edge   = fs_now && !m_fs_prev;
            rdy_edge  = rdy_flag && !m_rdy_prev;
            serr_edge = serr_flag && !m_serr_prev;
            slot_evt  = chan_strobe && (chan_last || m_cnt == 15);
            if (m_mode == 2)      exp_irq = fs_edge;
            else if (rcv_reset)   exp_irq = 0;
            else if (m_mode == 0) exp_irq = rdy_edge;
            else if (m_mode == 1) exp_irq = slot_evt && mc_en;
            else                  exp_irq = serr_edge;
            m_fs_prev = fs_now;
            void'(m_fs_q.pop_back());
            m_fs_q.push_front(fsync_raw);
            m_rdy_prev  = rcv_reset ? 1'b0 : rdy_flag;
            m_serr_prev = rcv_reset ? 1'b0 : serr_flag;
            if (rcv_reset || fs_edge) m_cnt = 0;
            else if (chan_strobe)     m_cnt = slot_evt ? 0 : m_cnt + 1;
            if (cfg_wr) m_mode = int'(cfg_wdata[5:4]);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R10 model irq", {15'd0, irq}, {15'd0, exp_irq});
            check("R9 model status", {14'd0, stat_syncerr, stat_ready}, {14'd0, serr_flag, rdy_flag});
            check("R1 model mode", cfg_rdata, 16'(m_mode << 4));
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic write_cfg(input logic [15:0] v);
        cfg_wr = 1'b1; cfg_wdata = v;
        tick();
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic fs_pulse();
        fsync_raw = 1'b1; tick();
        fsync_raw = 1'b0; tick(4);
    endtask

    initial begin
        @(negedge clk);
        tick(3);
        check("R1 reset irq", {15'd0, irq}, 16'd0);
        check("R1 reset mode", cfg_rdata, 16'h0000);
        rst_n = 1'b1;
        tick();

        // R2: mode 00 on ready rising
        rdy_flag = 1'b1; tick();
        check("R2 ready edge", {15'd0, irq}, 16'd1);
        check("R9 ready status", {15'd0, stat_ready}, 16'd1);
        tick();
        check("R2 single cycle", {15'd0, irq}, 16'd0);
        rdy_flag = 1'b0; tick();

        // R1: field position and spare bits
        write_cfg(16'hFFFF);
        check("R1 spare bits zero", cfg_rdata, 16'h0030);
        write_cfg(16'h0030);
        check("R1 mode 11 readback", cfg_rdata, 16'h0030);

        // R8: sync error source
        serr_flag = 1'b1; tick();
        check("R8 serr edge", {15'd0, irq}, 16'd1);
        check("R9 serr status", {15'd0, stat_syncerr}, 16'd1);
        tick();
        check("R8 single cycle", {15'd0, irq}, 16'd0);

        // R10: ready event ignored in mode 11 and not replayed in mode 00
        rdy_flag = 1'b1; tick();
        check("R10 ready ignored", {15'd0, irq}, 16'd0);
        serr_flag = 1'b0;
        write_cfg(16'h0000);
        tick(2);
        check("R10 not queued", {15'd0, irq}, 16'd0);

        // R11: receiver reset in mode 00
        rdy_flag = 1'b0; tick();
        rcv_reset = 1'b1; rdy_flag = 1'b1;
        tick(3);
        check("R11 suppressed", {15'd0, irq}, 16'd0);
        rcv_reset = 1'b0; tick();
        check("R11 history cleared", {15'd0, irq}, 16'd1);
        tick();
        rdy_flag = 1'b0; tick();

        // R3 / R4: multichannel block mode
        mc_en = 1'b1;
        write_cfg(16'h0010);
        fs_pulse();
        for (int i = 1; i <= 16; i++) begin
            chan_strobe = 1'b1; tick();
            check("R3 block boundary", {15'd0, irq}, (i == 16) ? 16'd1 : 16'd0);
        end
        for (int i = 1; i <= 3; i++) begin
            chan_strobe = 1'b1; chan_last = (i == 3); tick();
            check("R4 frame end", {15'd0, irq}, (i == 3) ? 16'd1 : 16'd0);
        end
        chan_strobe = 1'b0; chan_last = 1'b0;
        for (int i = 0; i < 10; i++) begin
            chan_strobe = 1'b1; tick();
        end
        chan_strobe = 1'b0;
        fs_pulse();
        for (int i = 1; i <= 16; i++) begin
            chan_strobe = 1'b1; tick();
            check("R4 restart at frame sync", {15'd0, irq}, (i == 16) ? 16'd1 : 16'd0);
        end
        chan_strobe = 1'b0;

        // R5: multichannel disabled
        mc_en = 1'b0;
        for (int i = 1; i <= 16; i++) begin
            chan_strobe = 1'b1; chan_last = (i == 16); tick();
            check("R5 mc disabled", {15'd0, irq}, 16'd0);
        end
        chan_strobe = 1'b0; chan_last = 1'b0; mc_en = 1'b1;

        // R6: frame-sync mode, held high
        write_cfg(16'h0020);
        fsync_raw = 1'b1;
        tick(2);
        check("R6 sync latency", {15'd0, irq}, 16'd0);
        tick();
        check("R6 frame sync", {15'd0, irq}, 16'd1);
        tick();
        check("R6 single pulse", {15'd0, irq}, 16'd0);
        tick(3);
        check("R6 held high", {15'd0, irq}, 16'd0);
        fsync_raw = 1'b0; tick(4);

        // R7: frame-sync while receiver in reset
        rcv_reset = 1'b1;
        fsync_raw = 1'b1;
        tick(3);
        check("R7 sync in reset", {15'd0, irq}, 16'd1);
        fsync_raw = 1'b0;
        tick(4);
        rcv_reset = 1'b0;
        tick(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule